// File: doc/BRIEF.md
# Power-On and Push-Button Reset Sequencer

This block produces the reset that every flip-flop of a single clock domain uses to preset or clear itself. While the power-good indication is low, reset is asserted at once, with no clock edge needed. When power-good rises, the release is passed through a two-stage synchronizer. A hold timer then keeps reset asserted for a fixed number of clock cycles, which covers supply settling. Only after that does reset deassert, on a clock edge.

A raw push-button input starts the same sequence again at any time. The button is synchronized and filtered, so a press must be seen on a minimum number of consecutive clock edges before it counts. While the filtered button is held, reset stays asserted and the hold timer is kept at zero. The full hold period starts only when the button is released.

Both polarities of reset are driven from registers. The active-high output feeds logic that clears on a high reset, and the active-low output feeds logic that clears on a low reset.

Top module: `rst_sequencer`

## Requirements
- R1: While `pwr_ok` is low, `rst_o` is 1 and `rst_n_o` is 0, and a fall of `pwr_ok` takes effect without any clock edge.
- R2: Count rising edges of `clk` from 1, starting at the first edge after `pwr_ok` rises, with the button idle. `rst_o` stays 1 through edge HOLD_CYCLES+1 and reads 0 after edge HOLD_CYCLES+2. Two of these edges are the release synchronizer.
- R3: `rst_o` never falls unless it has been 1 on at least HOLD_CYCLES consecutive clock edges.
- R4: A button press starts at edge s (`btn_raw` = 1 sampled at edges s onward) and lasts at least DB_CYCLES edges, while reset is low. `rst_o` reads 1 after edge s+DB_CYCLES+2 and not before.
- R5: While the filtered button is held, `rst_o` stays 1 whatever the state of the hold timer.
- R6: The button is released with `btn_raw` first sampled 0 at edge r. `rst_o` then falls at edge r+DB_CYCLES+1+HOLD_CYCLES.
- R7: A press seen on fewer than DB_CYCLES consecutive edges leaves `rst_o` at 0.
- R8: A press that is recognised while the power-up hold is still counting restarts the hold. Reset then falls at the R6 edge of that press, not at the power-up edge.
- R9: `rst_n_o` is always the complement of `rst_o`.
- R10: The filtered button may become active in the same cycle in which the hold timer reaches its last count. In that case the button wins and `rst_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the domain being reset |
| pwr_ok | input | 1 | Asynchronous power-good; low forces reset |
| btn_raw | input | 1 | Unsynchronized, active-high reset button |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |

## Verification
A newly recognised button press and the expiry of the hold timer can fall in the same cycle. The two requests conflict: one releases reset and the other demands it. The bench provokes this by raising power-good and then starting a press of exactly DB_CYCLES edges at edge HOLD_CYCLES−DB_CYCLES. That timing makes the filter output rise one edge before the timer would release. The result is judged correct only if `rst_o` never drops in between and falls exactly at the release edge computed from the button.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Counter width able to hold values 0 .. n-1, never narrower than one bit.
    function automatic int cnt_width(input int n);
        int w;
        w = (n <= 2) ? 1 : $clog2(n);
        return w;
    endfunction

endpackage

// File: rtl/rsq_sync2.sv
module rsq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        typedef struct packed {
            logic meta;
            logic stable;
        } stage_t;

        stage_t st_d, st_q;

        always_comb begin
            st_d.meta   = d[i];
            st_d.stable = st_q.meta;
        end

        always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) st_q <= '0;
            else         st_q <= st_d;
        end

        assign q[i] = st_q.stable;
    end
endmodule

// File: rtl/rsq_debounce.sv
module rsq_debounce #(
    parameter int DB_CYCLES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lvl_in,
    output logic lvl_out
);
    localparam int DW = rsq_pkg::cnt_width(DB_CYCLES);
    localparam logic [DW-1:0] LAST = DW'(DB_CYCLES - 1);

    typedef struct packed {
        logic          lvl;
        logic [DW-1:0] cnt;
    } db_t;

    db_t db_d, db_q;

    // The input must differ from the accepted level on DB_CYCLES consecutive
    // edges before the accepted level follows it.
    always_comb begin
        db_d = db_q;
        if (lvl_in != db_q.lvl) begin
            if (db_q.cnt == LAST) begin
                db_d.lvl = lvl_in;
                db_d.cnt = '0;
            end else begin
                db_d.cnt = db_q.cnt + 1'b1;
            end
        end else begin
            db_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) db_q <= '0;
        else         db_q <= db_d;
    end

    assign lvl_out = db_q.lvl;
endmodule

// File: rtl/rsq_hold_ctrl.sv
module rsq_hold_ctrl #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic run_ok,
    input  logic hold_req,
    output logic rst_hi,
    output logic rst_lo
);
    localparam int CW = rsq_pkg::cnt_width(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic [CW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    // Priority: missing power, then held button, then timer expiry.
    always_comb begin
        h_d = h_q;
        if (!run_ok || hold_req) begin
            h_d.hi  = 1'b1;
            h_d.lo  = 1'b0;
            h_d.cnt = '0;
        end else if (h_q.hi) begin
            if (h_q.cnt == LAST) begin
                h_d.hi  = 1'b0;
                h_d.lo  = 1'b1;
                h_d.cnt = '0;
            end else begin
                h_d.cnt = h_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            h_q.hi  <= 1'b1;
            h_q.lo  <= 1'b0;
            h_q.cnt <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rst_hi = h_q.hi;
    assign rst_lo = h_q.lo;
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
    parameter int HOLD_CYCLES = 16,
    parameter int DB_CYCLES   = 2
) (
    input  logic clk,
    input  logic pwr_ok,
    input  logic btn_raw,
    output logic rst_o,
    output logic rst_n_o
);
    logic [1:0] sync_q;
    logic       pwr_sync;
    logic       btn_sync;
    logic       btn_db;

    // Bit 0 carries a constant one that walks in once power-good releases
    // the flops; bit 1 carries the button.
    rsq_sync2 #(.W(2)) u_sync (
        .clk    (clk),
        .arst_n (pwr_ok),
        .d      ({btn_raw, 1'b1}),
        .q      (sync_q)
    );

    assign pwr_sync = sync_q[0];
    assign btn_sync = sync_q[1];

    rsq_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
        .clk     (clk),
        .arst_n  (pwr_ok),
        .lvl_in  (btn_sync),
        .lvl_out (btn_db)
    );

    rsq_hold_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .arst_n   (pwr_ok),
        .run_ok   (pwr_sync),
        .hold_req (btn_db),
        .rst_hi   (rst_o),
        .rst_lo   (rst_n_o)
    );
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk #(
    parameter int HOLD_CYCLES = 16
) (
    input logic clk,
    input logic pwr_ok,
    input logic btn_sync,
    input logic btn_db,
    input logic rst_o
);
    localparam int RW = $clog2(HOLD_CYCLES + 1) + 1;
    localparam logic [RW-1:0] SAT = RW'(HOLD_CYCLES);

    logic [RW-1:0] run_q;

    // Consecutive edges on which reset was seen high, saturating.
    always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok)      run_q <= '0;
        else if (!rst_o)  run_q <= '0;
        else if (run_q != SAT) run_q <= run_q + 1'b1;
    end

    AST_RELEASE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!pwr_ok)
        $fell(rst_o) |-> (run_q >= SAT)); // R3

    AST_RISE_ONLY_FROM_BUTTON: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(rst_o) |-> $past(btn_db)); // R4

    AST_BUTTON_HOLDS_RESET: assert property (@(posedge clk) disable iff (!pwr_ok)
        btn_db |=> rst_o); // R5

    AST_FILTER_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!pwr_ok)
        $rose(btn_db) |-> $past(btn_sync)); // R7

    AST_BUTTON_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!pwr_ok)
        $fell(rst_o) |-> !$past(btn_db)); // R10
endmodule

bind rst_sequencer rst_sequencer_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .btn_sync (btn_sync),
    .btn_db   (btn_db),
    .rst_o    (rst_o)
);

// File: tb/rst_sequencer_tb_top.sv
`timescale 1ns/1ps
module rst_sequencer_tb_top;
    localparam int H  = 10;
    localparam int DB = 2;

    logic clk = 1'b0;
    logic pwr_ok = 1'b1;
    logic btn_raw = 1'b0;
    logic rst_o, rst_n_o;

    int total = 0;
    int bad = 0;
    int comp_bad;
    logic trace [0:255];

    always #2.5 clk = ~clk;

    rst_sequencer #(.HOLD_CYCLES(H), .DB_CYCLES(DB)) dut_i (
        .clk     (clk),
        .pwr_ok  (pwr_ok),
        .btn_raw (btn_raw),
        .rst_o   (rst_o),
        .rst_n_o (rst_n_o)
    );

    function automatic int exp_rise(input int s);
        return s + DB + 2;
    endfunction

    function automatic int exp_fall(input int s, input int len);
        return s + len + DB + 1 + H;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Run n edges; optionally raise power before edge 1; press the button
    // for edges s .. s+len-1. trace[k] is rst_o just after edge k.
    task automatic watch(input bit do_pwr, input int s, input int len, input int n);
        comp_bad = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (do_pwr && k == 1) pwr_ok = 1'b1;
            btn_raw = (k >= s && k < s + len);
            @(posedge clk);
            #1;
            trace[k] = rst_o;
            if (rst_n_o !== ~rst_o) comp_bad++;
        end
        btn_raw = 1'b0;
    endtask

    // Expect rst_o high exactly on edges a .. b-1 within 1..n.
    task automatic check_trace(input int a, input int b, input int n, input string req);
        int first_bad;
        first_bad = 0;
        for (int k = n; k >= 1; k--)
            if (trace[k] !== (k >= a && k < b)) first_bad = k;
        check(first_bad == 0, req, "rst_o trace mismatch at edge",
              (first_bad == 0) ? 0 : int'(trace[first_bad]),
              (first_bad == 0) ? 0 : int'(first_bad >= a && first_bad < b));
        if (first_bad != 0) $display("  (edge %0d, window %0d..%0d)", first_bad, a, b - 1);
        check(comp_bad == 0, "R9", "complement mismatches", comp_bad, 0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
    endtask

    task automatic power_drop;
        @(negedge clk);
        #1 pwr_ok = 1'b0;
        #0.5;
        check(rst_o === 1'b1 && rst_n_o === 1'b0, "R1", "async assert rst_o",
              int'(rst_o), 1);
        idle(2);
    endtask

    initial begin
        void'($urandom(32'd4711));
        #2 pwr_ok = 1'b0;
        #0.2;
        // R1: reset state, no clock edge yet
        check(rst_o === 1'b1, "R1", "reset-state rst_o", int'(rst_o), 1);
        check(rst_n_o === 1'b0, "R1", "reset-state rst_n_o", int'(rst_n_o), 0);
        idle(3);

        // R2, R3: plain power-up release
        watch(1'b1, 0, 0, H + 8);
        check_trace(1, H + 2, H + 8, "R2");

        // R4, R5, R6: random full presses
        for (int it = 0; it < 20; it++) begin
            int s, len, n;
            s   = $urandom_range(1, 3);
            len = $urandom_range(DB, 12);
            n   = exp_fall(s, len) + 4;
            watch(1'b0, s, len, n);
            check_trace(exp_rise(s), exp_fall(s, len), n, "R4/R5/R6");
            idle($urandom_range(0, 4));
        end

        // R7: glitches shorter than the filter window
        for (int it = 0; it < 5; it++) begin
            watch(1'b0, $urandom_range(1, 4), DB - 1, 14);
            check_trace(0, 0, 14, "R7");
        end

        // R1: asynchronous drop during normal operation, then R8 restart
        power_drop();
        watch(1'b1, 4, 3, exp_fall(4, 3) + 4);
        check_trace(1, exp_fall(4, 3), exp_fall(4, 3) + 4, "R8");

        // R10: filtered press becomes active on the expiry cycle
        power_drop();
        watch(1'b1, H - DB, DB, exp_fall(H - DB, DB) + 4);
        check_trace(1, exp_fall(H - DB, DB), exp_fall(H - DB, DB) + 4, "R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule